// File: doc/BRIEF.md
# Microwire serial memory slave

This block is the device side of a small serial memory reached over a three-wire select/clock/data bus. The data-out line can be tri-stated. While select is high, the block waits for a start bit. It then takes in a two-bit opcode, an address and, for a write, a data word. A read sends a zero bit first and then the addressed word, most significant bit first. A write or erase starts a self-timed program cycle. The cycle lasts a fixed number of system clocks and finishes whatever select does afterwards.

Select, serial clock and data-in are synchronized into the system clock domain. Every bus action happens on a rising serial-clock edge seen in that domain. A static strap input picks 8-bit or 16-bit words. The storage is a register array of 16-bit words. In 8-bit mode each byte of a word is addressed separately.

After a program cycle has started, the host can drop select and raise it again to poll the cycle. The data-out line then shows low while the cycle is busy and high once it is done.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, data-out is not driven (do_oe_o low) and every word of the array reads as zero.
- R2: While select is low, the decoder is held idle. Dropping select partway through a command discards it, and the array is unchanged.
- R3: While select is high, a serial-clock rising edge with data-in low before a start bit changes nothing and leaves data-out undriven.
- R4: The opcode follows the start bit and is taken MSB first: 10 read, 01 write, 11 erase, 00 extended. The address is 6 bits with org_i high and 7 bits with org_i low. A read drives a zero bit from the rising edge of the last address bit, then one word bit per rising edge, MSB first.
- R5: With org_i high, a write stores the 16 data bits that follow the address, MSB first, in the addressed word.
- R6: With org_i low, words are 8 bits. Address bit 0 set selects the upper byte of 16-bit word address[6:1], and clear selects the lower byte. The other byte is kept.
- R7: An erase sets every bit of the addressed word, or of the addressed byte in 8-bit mode, to one.
- R8: A program cycle holds busy for PROG_CYCLES system clocks and completes even if select drops during it.
- R9: If select rises while a program cycle is busy, data-out is driven low until the cycle ends and high afterwards. This lasts until select falls or a new start bit is accepted.
- R10: If select stays high, or stays low, through a whole program cycle, no status is driven on data-out.
- R11: Once an instruction's last bit has been taken, further clocks and data are ignored until select goes low. A read releases data-out on the rising edge after its least significant bit.
- R12: A start bit that arrives while a program cycle is busy is rejected. The bits that follow it have no effect on the array.
- R13: The extended opcode uses up its address bits and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus select, active high |
| sclk_i | input | 1 | Serial bus clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word-size strap: 0 selects 8-bit words, 1 selects 16-bit words |
| do_o | output | 1 | Serial data out (read data or busy/ready status) |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
A program cycle in progress and the start of a new command can overlap: select is re-raised to show status, and the host starts clocking in the next instruction. The bench sends a complete write while the status line still reads busy, with a program cycle long enough to cover every bit of it. It then checks three things: status stays driven low throughout, the ready level follows at the expected time, and a later read returns the first write's data rather than the second's.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } mw_state_e;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } mw_op_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= '0;
      else if (g == 0) chain[g] <= d_i;
      else chain[g] <= chain[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CW'(PROG_CYCLES - 1);
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8: busy cannot end early
  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0) |=> busy_o);
  // R8: busy only begins on a start request
  a_r8_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int WORDS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [$clog2(WORDS)-1:0] wr_idx_i,
  input  logic [1:0]               wr_be_i,
  input  logic [15:0]              wr_data_i,
  input  logic [$clog2(WORDS)-1:0] rd_idx_i,
  output logic [15:0]              rd_data_o
);
  logic [15:0] arr_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 2; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) arr_q[w][b*8 +: 8] <= '0;
        else if (wr_en_i && wr_be_i[b] && wr_idx_i == w)
          arr_q[w][b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
  end

  assign rd_data_o = arr_q[rd_idx_i];
endmodule

// File: rtl/mw_cmd.sv
module mw_cmd
  import mw_pkg::*;
#(
  parameter int AW16 = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_s_i,
  input  logic            sclk_rise_i,
  input  logic            di_s_i,
  input  logic            org_i,
  input  logic            busy_i,
  input  logic [15:0]     rd_word_i,
  output logic [AW16-1:0] rd_idx_o,
  output logic            wr_en_o,
  output logic [AW16-1:0] wr_idx_o,
  output logic [1:0]      wr_be_o,
  output logic [15:0]     wr_data_o,
  output logic            prog_start_o,
  output logic            rd_active_o,
  output logic            rd_bit_o,
  output logic            stat_o
);
  localparam int AW8 = AW16 + 1;
  localparam int CW  = $clog2(((AW8 > 16) ? AW8 : 16) + 1);

  mw_state_e      state_q;
  mw_op_e         opc_q;
  logic [CW-1:0]  cnt_q;
  logic [AW8-1:0] addr_q;
  logic [15:0]    sh_q;
  logic           cs_prev_q;

  logic [CW-1:0]   aw, dw;
  logic [AW8-1:0]  addr_nxt;
  logic [AW16-1:0] nxt_idx, cur_idx;
  logic            nxt_hi, cur_hi;
  logic [15:0]     data_nxt;
  logic            start_ok;

  assign aw       = org_i ? CW'(AW16) : CW'(AW8);
  assign dw       = org_i ? CW'(16) : CW'(8);
  assign addr_nxt = {addr_q[AW8-2:0], di_s_i};
  assign nxt_idx  = org_i ? addr_nxt[AW16-1:0] : addr_nxt[AW8-1:1];
  assign nxt_hi   = addr_nxt[0];
  assign cur_idx  = org_i ? addr_q[AW16-1:0] : addr_q[AW8-1:1];
  assign cur_hi   = addr_q[0];
  assign data_nxt = {sh_q[14:0], di_s_i};
  assign rd_idx_o = nxt_idx;
  assign start_ok = (state_q == ST_IDLE) && sclk_rise_i && di_s_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b0;
    else cs_prev_q <= cs_s_i;
  end

  // busy/ready status window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= 1'b0;
    else if (!cs_s_i) stat_o <= 1'b0;
    else if (!cs_prev_q && busy_i) stat_o <= 1'b1;
    else if (start_ok) stat_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      opc_q        <= OP_EXT;
      cnt_q        <= '0;
      addr_q       <= '0;
      sh_q         <= '0;
      rd_bit_o     <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_idx_o     <= '0;
      wr_be_o      <= '0;
      wr_data_o    <= '0;
      prog_start_o <= 1'b0;
    end else begin
      wr_en_o      <= 1'b0;
      prog_start_o <= 1'b0;
      if (!cs_s_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (sclk_rise_i) begin
        unique case (state_q)
          ST_IDLE: if (start_ok) begin
            state_q <= ST_OPC;
            cnt_q   <= '0;
            addr_q  <= '0;
          end
          ST_OPC: begin
            opc_q <= mw_op_e'({opc_q[0], di_s_i});
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(1)) begin
              state_q <= ST_ADDR;
              cnt_q   <= '0;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_nxt;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == aw - 1'b1) begin
              cnt_q <= '0;
              unique case (opc_q)
                OP_READ: begin
                  state_q  <= ST_READ;
                  rd_bit_o <= 1'b0;
                  sh_q     <= org_i ? rd_word_i
                            : {(nxt_hi ? rd_word_i[15:8] : rd_word_i[7:0]), 8'h00};
                end
                OP_WRITE: begin
                  state_q <= ST_DATA;
                  sh_q    <= '0;
                end
                OP_ERASE: begin
                  state_q      <= ST_DONE;
                  wr_en_o      <= 1'b1;
                  prog_start_o <= 1'b1;
                  wr_idx_o     <= nxt_idx;
                  wr_be_o      <= org_i ? 2'b11 : {nxt_hi, !nxt_hi};
                  wr_data_o    <= 16'hFFFF;
                end
                default: state_q <= ST_DONE;
              endcase
            end
          end
          ST_DATA: begin
            sh_q  <= data_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == dw - 1'b1) begin
              state_q      <= ST_DONE;
              wr_en_o      <= 1'b1;
              prog_start_o <= 1'b1;
              wr_idx_o     <= cur_idx;
              wr_be_o      <= org_i ? 2'b11 : {cur_hi, !cur_hi};
              wr_data_o    <= org_i ? data_nxt : {data_nxt[7:0], data_nxt[7:0]};
            end
          end
          ST_READ: begin
            if (cnt_q == dw) state_q <= ST_DONE;
            else begin
              rd_bit_o <= sh_q[15];
              sh_q     <= {sh_q[14:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active_o = (state_q == ST_READ);

  // R12: no new program cycle is launched while one is running
  a_r12_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> !busy_i);
  // R11: a finished instruction stays finished while selected
  a_r11_done_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && cs_s_i) |=> state_q == ST_DONE);
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int MEM_BITS    = 1024,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  localparam int WORDS = MEM_BITS / 16;
  localparam int AW16  = $clog2(WORDS);

  logic [2:0]      sync_q;
  logic            cs_s, sclk_s, di_s, sclk_prev_q, sclk_rise;
  logic            busy, prog_start, wr_en, rd_active, rd_bit, stat;
  logic [AW16-1:0] rd_idx, wr_idx;
  logic [1:0]      wr_be;
  logic [15:0]     wr_data, rd_word;

  mw_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_i, sclk_i, di_i}), .q_o(sync_q)
  );
  assign {cs_s, sclk_s, di_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else sclk_prev_q <= sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_prev_q;

  mw_cmd #(.AW16(AW16)) u_cmd (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .sclk_rise_i(sclk_rise), .di_s_i(di_s), .org_i,
    .busy_i(busy), .rd_word_i(rd_word), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_be_o(wr_be), .wr_data_o(wr_data),
    .prog_start_o(prog_start), .rd_active_o(rd_active), .rd_bit_o(rd_bit),
    .stat_o(stat)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy)
  );

  mw_mem #(.WORDS(WORDS)) u_mem (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_be_i(wr_be),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_word)
  );

  assign do_oe_o = rd_active || stat;
  assign do_o    = rd_active ? rd_bit : !busy;

  // R2: deselect releases data-out on the next clock
  a_r2_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !do_oe_o);
  // R9: status window shows low while the program cycle runs
  a_r9_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat && busy) |-> (do_oe_o && !do_o));
endmodule

// File: tb/mw_eeprom_slave_tb.sv
`timescale 1ns/1ps
module mw_eeprom_slave_tb;
  localparam int PROG = 400;
  localparam int PH   = 6;

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, di = 0, org = 1;
  logic dout, doe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mw_eeprom_slave #(.MEM_BITS(1024), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
    .org_i(org), .do_o(dout), .do_oe_o(doe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    di = b; wait_clk(PH); sclk = 1; wait_clk(PH); sclk = 0;
  endtask

  task automatic cs_up;   cs = 1; wait_clk(PH); endtask
  task automatic cs_down; cs = 0; di = 0; wait_clk(PH); endtask

  task automatic send_head(input logic [1:0] op, input int addr, input int aw);
    bit_out(1); bit_out(op[1]); bit_out(op[0]);
    for (int i = aw - 1; i >= 0; i--) bit_out(addr[i]);
  endtask

  task automatic do_write(input int addr, input int data, input bit wait_done);
    int aw = org ? 6 : 7, dw = org ? 16 : 8;
    cs_up; send_head(2'b01, addr, aw);
    for (int i = dw - 1; i >= 0; i--) bit_out(data[i]);
    cs_down;
    if (wait_done) wait_clk(PROG + 20);
  endtask

  task automatic do_read(input int addr, input int exp, input string req);
    int aw = org ? 6 : 7, dw = org ? 16 : 8, got = 0;
    cs_up; send_head(2'b10, addr, aw);
    chk(doe === 1'b1 && dout === 1'b0, {req, " dummy"}, {doe, dout}, 2);
    for (int i = 0; i < dw; i++) begin
      bit_out(0);
      got = (got << 1) | int'(dout);
    end
    chk(got == exp, req, got, exp);
    bit_out(0);
    chk(doe === 1'b0, "R11 release after lsb", doe, 0);
    cs_down;
  endtask

  task automatic t_reset;
    chk(doe === 1'b0, "R1 oe after reset", doe, 0);
    do_read(5, 0, "R1 zero word");
  endtask

  task automatic t_write16;
    org = 1;
    do_write(3, 16'hA5C3, 1);
    do_read(3, 16'hA5C3, "R5 write x16");
    do_read(4, 0, "R4 neighbour word");
  endtask

  task automatic t_x8;
    org = 0;
    do_write(7, 8'h5A, 1);
    do_read(7, 8'h5A, "R6 upper byte");
    do_read(6, 8'hC3, "R6 lower byte kept");
    org = 1;
    do_read(3, 16'h5AC3, "R6 word view");
  endtask

  task automatic t_erase;
    org = 1;
    cs_up; send_head(2'b11, 10, 6); cs_down; wait_clk(PROG + 20);
    do_read(10, 16'hFFFF, "R7 erase x16");
    org = 0;
    cs_up; send_head(2'b11, 6, 7); cs_down; wait_clk(PROG + 20);
    org = 1;
    do_read(3, 16'h5AFF, "R7 erase byte");
  endtask

  task automatic t_status_overlap;
    org = 1;
    do_write(12, 16'h1234, 0);
    cs_up;
    chk(doe === 1'b1 && dout === 1'b0, "R9 busy shown", {doe, dout}, 2);
    // full write while busy, must be rejected
    send_head(2'b01, 12, 6);
    for (int i = 15; i >= 0; i--) bit_out(1'b1);
    chk(doe === 1'b1 && dout === 1'b0, "R12 still busy", {doe, dout}, 2);
    wait_clk(PROG);
    chk(doe === 1'b1 && dout === 1'b1, "R9 ready shown", {doe, dout}, 3);
    cs_down;
    chk(doe === 1'b0, "R9 released on deselect", doe, 0);
    do_read(12, 16'h1234, "R12 array unchanged");
  endtask

  task automatic t_length;
    org = 1;
    do_write(21, 16'h0F0F, 0);   // select drops right after the command
    cs_up;
    wait_clk(PROG - 60);
    chk(dout === 1'b0, "R8 still busy", dout, 0);
    wait_clk(80);
    chk(dout === 1'b1, "R8 finished", dout, 1);
    cs_down;
    do_read(21, 16'h0F0F, "R8 completed");
  endtask

  task automatic t_no_status;
    bit seen = 0;
    org = 1;
    cs_up; send_head(2'b01, 20, 6);
    for (int i = 15; i >= 0; i--) bit_out(i[0]);
    for (int i = 0; i < PROG / 10 + 4; i++) begin
      wait_clk(10);
      if (doe !== 1'b0) seen = 1;
    end
    chk(!seen, "R10 held high", seen, 0);
    cs_down;
    do_write(22, 16'h00FF, 0);
    wait_clk(PROG + 20);
    cs_up;
    chk(doe === 1'b0, "R10 held low", doe, 0);
    cs_down;
  endtask

  task automatic t_leading_zeros;
    org = 1;
    cs_up;
    for (int i = 0; i < 5; i++) bit_out(0);
    chk(doe === 1'b0, "R3 zeros ignored", doe, 0);
    send_head(2'b10, 3, 6);
    chk(doe === 1'b1, "R3 start after zeros", doe, 1);
    cs_down;
  endtask

  task automatic t_abort;
    org = 1;
    cs_up; bit_out(1); bit_out(0); bit_out(1); bit_out(0); bit_out(1);
    cs_down;
    chk(doe === 1'b0, "R2 abort idle", doe, 0);
    do_read(3, 16'h5AFF, "R2 aborted write");
  endtask

  task automatic t_extra_bits;
    bit seen = 0;
    org = 1;
    cs_up; send_head(2'b10, 3, 6);
    for (int i = 0; i < 17; i++) bit_out(0);
    // pattern that would start a read if not ignored
    for (int i = 0; i < 10; i++) begin
      bit_out(i < 2);
      if (doe !== 1'b0) seen = 1;
    end
    chk(!seen, "R11 extra clocks ignored", seen, 0);
    cs_down;
  endtask

  task automatic t_ext;
    bit seen = 0;
    org = 1;
    cs_up; send_head(2'b00, 6'h3F, 6);
    for (int i = 0; i < 16; i++) begin
      bit_out(1);
      if (doe !== 1'b0) seen = 1;
    end
    chk(!seen, "R13 no output", seen, 0);
    cs_down;
    wait_clk(PROG + 20);
    do_read(6'h3F, 0, "R13 no write");
    do_read(3, 16'h5AFF, "R13 word kept");
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    t_reset;
    t_write16;
    t_x8;
    t_erase;
    t_status_overlap;
    t_length;
    t_no_status;
    t_leading_zeros;
    t_abort;
    t_extra_bits;
    t_ext;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule